// File: doc/BRIEF.md
# Real-Time Urgency Flag Generator

This block grades how urgently a camera-capture write DMA needs memory service. The write DMA reports a live count of slots that are ready to issue memory transactions. The block compares that count with two 8-bit thresholds held in a 32-bit control word. The result is a 2-bit urgency flag for the interconnect: 00 means no urgency, 01 means moderate urgency and 11 means high urgency.

Choosing the thresholds at their extremes gives three fixed modes. In the first, the flag is held off. In the other two, the flag is pinned to a constant code for debug. A separate bit in the control word lets a non-zero flag also hold back the read DMA that feeds the internal pipeline. This keeps non-real-time data out of FIFO slots that both sides share.

Both outputs are registered. Software loads the control word through a single-cycle write strobe with a 32-bit data bus. The slot count is a plain 8-bit input whose value never exceeds 254.

Top module: `rt_urgency_flag_gen`

## Requirements
- R1: The control word is loaded from `ctrl_wdata_i` on a rising edge where `ctrl_we_i` is high. Its fields are placed as follows:
  - the low threshold is bits [20:13];
  - the high threshold is bits [31:24];
  - the read-stall enable is bit 22.
- R2: Let n be `slots_ready_i`, with 0 <= n <= 254. Then `urg_flag_o[1]` = (n >= low threshold), and `urg_flag_o[0]` = (n >= low threshold) OR (n >= high threshold). As a result the code 10 never appears.
- R3: With both thresholds at 0xFF, `urg_flag_o` stays 00 for every n from 0 to 254.
- R4: With the low threshold at 0x00, `urg_flag_o` is 11 for every n, whatever the high threshold.
- R5: With the low threshold at 0xFF and the high threshold at 0x00, `urg_flag_o` is 01 for every n.
- R6: With the stall enable set, `rd_stall_o` is high exactly when the flag registered on the same edge is non-zero. The two outputs always change on the same edge.
- R7: With the stall enable clear, `rd_stall_o` stays low whatever the flag.
- R8: Timing of the outputs:
  - a new n sampled on a rising edge shows on the outputs right after that edge;
  - a control write on edge k first affects the outputs after edge k+1;
  - a write and a new n in the same cycle give one cycle of new n with the old thresholds.
- R9: A synchronous active-high reset clears `urg_flag_o` and `rd_stall_o`. It also restores the control word to both thresholds at 0xFF with the stall disabled, which is 0xFF1FE000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word write data |
| slots_ready_i | input | 8 | Count of write-DMA slots ready to issue (0..254) |
| urg_flag_o | output | 2 | Registered urgency flag |
| rd_stall_o | output | 1 | Registered stall request to the read DMA |

## Verification
A control write and a change of the slot count can land in the same clock cycle. When they do, the slot count goes through the flag path one edge earlier than the new thresholds. The bench drives both on one falling edge, with values chosen so that the old and new threshold pairs give different codes. It then expects the code from the new count and old thresholds first, and the code from the new thresholds one cycle later. On both of those cycles the stall output must follow the stall enable that is in force at that moment.

// File: rtl/urg_pkg.sv
package urg_pkg;

   typedef logic [1:0] urg_flag_t;

   localparam urg_flag_t URG_NONE = 2'b00;
   localparam urg_flag_t URG_MID  = 2'b01;
   localparam urg_flag_t URG_HIGH = 2'b11;

   // Folds the two threshold comparisons into the flag code.
   function automatic urg_flag_t urg_encode(input logic ge_lo, input logic ge_hi);
      urg_flag_t f;
      f[1] = ge_lo;
      f[0] = ge_lo | ge_hi;
      return f;
   endfunction

endpackage

// File: rtl/urg_ctrl_reg.sv
module urg_ctrl_reg #(
   parameter int CTRL_W    = 32,
   parameter int THR_W     = 8,
   parameter int LO_LSB    = 13,
   parameter int HI_LSB    = 24,
   parameter int STALL_BIT = 22
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output logic [THR_W-1:0]  lo_thr,
   output logic [THR_W-1:0]  hi_thr,
   output logic              stall_en
);

   localparam logic [CTRL_W-1:0] THR_ONES = {{(CTRL_W-THR_W){1'b0}}, {THR_W{1'b1}}};
   localparam logic [CTRL_W-1:0] RST_VAL  = (THR_ONES << LO_LSB) | (THR_ONES << HI_LSB);

   logic [CTRL_W-1:0] word_q;

   always_ff @(posedge clk) begin
      if (rst)        word_q <= RST_VAL;
      else if (wr_en) word_q <= wr_data;
   end

   assign lo_thr   = word_q[LO_LSB +: THR_W];
   assign hi_thr   = word_q[HI_LSB +: THR_W];
   assign stall_en = word_q[STALL_BIT];

endmodule

// File: rtl/urg_thr_cmp.sv
module urg_thr_cmp #(
   parameter int W    = 8,
   parameter int IMPL = 0   // 0: magnitude compare, 1: borrow of a subtraction
) (
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] thr,
   output logic         ge
);

   generate
      if (IMPL == 0) begin : g_mag
         assign ge = (cnt >= thr);
      end else begin : g_sub
         logic [W:0] diff;
         assign diff = {1'b0, cnt} - {1'b0, thr};
         assign ge   = ~diff[W];
      end
   endgenerate

endmodule

// File: rtl/urg_out_reg.sv
module urg_out_reg
   import urg_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  urg_flag_t flag_d,
   input  logic      stall_en,
   output urg_flag_t flag_q,
   output logic      stall_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         flag_q  <= URG_NONE;
         stall_q <= 1'b0;
      end else begin
         flag_q  <= flag_d;
         stall_q <= stall_en & (flag_d != URG_NONE);
      end
   end

endmodule

// File: rtl/rt_urgency_flag_gen.sv
module rt_urgency_flag_gen
   import urg_pkg::*;
#(
   parameter int CTRL_W    = 32,
   parameter int CNT_W     = 8,
   parameter int LO_LSB    = 13,
   parameter int HI_LSB    = 24,
   parameter int STALL_BIT = 22,
   parameter int CMP_IMPL  = 0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              ctrl_we_i,
   input  logic [CTRL_W-1:0] ctrl_wdata_i,
   input  logic [CNT_W-1:0]  slots_ready_i,
   output logic [1:0]        urg_flag_o,
   output logic              rd_stall_o
);

   localparam int THR_W = CNT_W;

   generate
      if (LO_LSB + THR_W > CTRL_W || HI_LSB + THR_W > CTRL_W) begin : g_bad_field
         $error("threshold field exceeds control word");
      end
      if (STALL_BIT >= CTRL_W) begin : g_bad_stall
         $error("stall bit outside control word");
      end
      if ((STALL_BIT >= LO_LSB && STALL_BIT < LO_LSB + THR_W) ||
          (STALL_BIT >= HI_LSB && STALL_BIT < HI_LSB + THR_W)) begin : g_bad_overlap
         $error("stall bit overlaps a threshold field");
      end
      if (CMP_IMPL < 0 || CMP_IMPL > 1) begin : g_bad_impl
         $error("unknown comparator variant");
      end
   endgenerate

   logic [THR_W-1:0] lo_thr;
   logic [THR_W-1:0] hi_thr;
   logic             stall_en;
   logic             ge_lo;
   logic             ge_hi;
   urg_flag_t        flag_d;
   urg_flag_t        flag_q;

   urg_ctrl_reg #(
      .CTRL_W(CTRL_W), .THR_W(THR_W), .LO_LSB(LO_LSB),
      .HI_LSB(HI_LSB), .STALL_BIT(STALL_BIT)
   ) u_ctrl (
      .clk(clk_i), .rst(rst_i), .wr_en(ctrl_we_i), .wr_data(ctrl_wdata_i),
      .lo_thr(lo_thr), .hi_thr(hi_thr), .stall_en(stall_en)
   );

   urg_thr_cmp #(.W(THR_W), .IMPL(CMP_IMPL)) u_cmp_lo (
      .cnt(slots_ready_i), .thr(lo_thr), .ge(ge_lo)
   );

   urg_thr_cmp #(.W(THR_W), .IMPL(CMP_IMPL)) u_cmp_hi (
      .cnt(slots_ready_i), .thr(hi_thr), .ge(ge_hi)
   );

   assign flag_d = urg_encode(ge_lo, ge_hi);

   urg_out_reg u_out (
      .clk(clk_i), .rst(rst_i), .flag_d(flag_d), .stall_en(stall_en),
      .flag_q(flag_q), .stall_q(rd_stall_o)
   );

   assign urg_flag_o = flag_q;

endmodule

// File: rtl/urg_chk.sv
module urg_chk #(
   parameter int THR_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             wr_en,
   input logic [THR_W-1:0] n,
   input logic [1:0]       flag,
   input logic             stall,
   input logic [THR_W-1:0] lo_thr,
   input logic [THR_W-1:0] hi_thr,
   input logic             stall_en
);

   localparam logic [THR_W-1:0] ONES = {THR_W{1'b1}};

   // R2
   flag_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
      flag != 2'b10);

   // R6
   stall_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
      stall |-> (flag != 2'b00));

   // R7
   stall_disabled_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(stall_en)) |-> !stall);

   // R3
   flag_off_mode_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(lo_thr) == ONES && $past(hi_thr) == ONES && $past(n) != ONES)
      |-> flag == 2'b00);

   // R4
   static_high_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(lo_thr) == '0) |-> flag == 2'b11);

   // R8
   hold_when_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      ($stable(n) && !$past(wr_en) && !$past(rst)) |=> $stable(flag));

   // R9
   reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (flag == 2'b00 && !stall));

endmodule

bind rt_urgency_flag_gen urg_chk #(.THR_W(THR_W)) u_urg_chk (
   .clk(clk_i), .rst(rst_i), .wr_en(ctrl_we_i), .n(slots_ready_i),
   .flag(urg_flag_o), .stall(rd_stall_o),
   .lo_thr(lo_thr), .hi_thr(hi_thr), .stall_en(stall_en)
);

// File: tb/tb_rt_urgency_flag_gen.sv
module tb_rt_urgency_flag_gen;

   logic        clk = 1'b0;
   logic        rst;
   logic        we;
   logic [31:0] wdata;
   logic [7:0]  n;
   logic [1:0]  flag;
   logic        stall;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   always #2 clk = ~clk;   // 250 MHz

   rt_urgency_flag_gen dut (
      .clk_i(clk), .rst_i(rst), .ctrl_we_i(we), .ctrl_wdata_i(wdata),
      .slots_ready_i(n), .urg_flag_o(flag), .rd_stall_o(stall)
   );

   function automatic logic [31:0] mk_ctrl(input logic [7:0] lo, input logic [7:0] hi,
                                           input logic en);
      logic [31:0] w = 32'h0;
      w[20:13] = lo;
      w[31:24] = hi;
      w[22]    = en;
      return w;
   endfunction

   function automatic logic [1:0] exp_flag(input logic [7:0] cnt, input logic [7:0] lo,
                                           input logic [7:0] hi);
      if (cnt >= lo)      return 2'b11;
      else if (cnt >= hi) return 2'b01;
      else                return 2'b00;
   endfunction

   task automatic check(input string req, input logic [1:0] ef, input logic es);
      vectors++;
      if (flag !== ef || stall !== es) begin
         errors++;
         $display("FAIL %s: flag=%b stall=%b expected flag=%b stall=%b (n=%0d)",
                  req, flag, stall, ef, es, n);
      end
   endtask

   // Drives a control word; new thresholds are live for the next n applied.
   task automatic write_ctrl(input logic [31:0] w);
      @(negedge clk);
      we = 1'b1; wdata = w;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic apply(input logic [7:0] cnt, input string req, input logic [1:0] ef,
                        input logic es);
      n = cnt;
      @(negedge clk);
      check(req, ef, es);
   endtask

   task automatic sweep(input logic [7:0] lo, input logic [7:0] hi, input logic en,
                        input string req);
      write_ctrl(mk_ctrl(lo, hi, en));
      for (int i = 0; i <= 254; i++) begin
         logic [1:0] ef = exp_flag(8'(i), lo, hi);
         apply(8'(i), req, ef, en & (ef != 2'b00));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd4097);
      rst = 1'b1; we = 1'b0; wdata = '0; n = 8'd200;
      repeat (3) @(negedge clk);
      check("R9 outputs in reset", 2'b00, 1'b0);
      rst = 1'b0;
      // R9: reset control word disables the flag even at a high count
      apply(8'd200, "R9 reset control word", 2'b00, 1'b0);
      apply(8'd254, "R9 reset control word", 2'b00, 1'b0);

      // R3: disable mode over full range, stall enabled must still stay low
      sweep(8'hFF, 8'hFF, 1'b1, "R3 off mode");
      // R4: static high code
      sweep(8'h00, 8'h37, 1'b1, "R4 static high");
      // R5: static mid code
      sweep(8'hFF, 8'h00, 1'b0, "R5 static mid");
      write_ctrl(mk_ctrl(8'hFF, 8'h00, 1'b1));
      apply(8'd9, "R6 static mid with stall", 2'b01, 1'b1);

      // R1/R2: directed threshold edges
      write_ctrl(mk_ctrl(8'd100, 8'd40, 1'b1));
      apply(8'd39,  "R2 below both", 2'b00, 1'b0);
      apply(8'd40,  "R2 at high thr", 2'b01, 1'b1);
      apply(8'd99,  "R2 just below low", 2'b01, 1'b1);
      apply(8'd100, "R1 R2 at low thr", 2'b11, 1'b1);
      // low below high: crossing low gives 11 directly
      write_ctrl(mk_ctrl(8'd20, 8'd60, 1'b0));
      apply(8'd19, "R2 low<high below", 2'b00, 1'b0);
      apply(8'd20, "R7 R2 low<high at low", 2'b11, 1'b0);
      apply(8'd60, "R7 stall off", 2'b11, 1'b0);

      // R8: write and count change in the same cycle
      @(negedge clk);
      n = 8'd50; we = 1'b1; wdata = mk_ctrl(8'd200, 8'd45, 1'b1);
      @(negedge clk);
      we = 1'b0;
      check("R8 new n with old thresholds", 2'b11, 1'b0);
      @(negedge clk);
      check("R8 new thresholds applied", 2'b01, 1'b1);

      // R2/R6/R7: random threshold pairs, full count sweeps
      for (int k = 0; k < 6; k++) begin
         logic [7:0] lo = 8'(1 + ($urandom % 254));
         logic [7:0] hi = 8'($urandom % 256);
         logic       en = 1'($urandom % 2);
         sweep(lo, hi, en, "R2 R6 random sweep");
      end

      // R9: reset mid-run restores disabled control word
      write_ctrl(mk_ctrl(8'd0, 8'd0, 1'b1));
      apply(8'd5, "R4 before reset", 2'b11, 1'b1);
      rst = 1'b1;
      @(negedge clk);
      check("R9 reset clears", 2'b00, 1'b0);
      rst = 1'b0;
      apply(8'd254, "R9 control word restored", 2'b00, 1'b0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule